// File: doc/BRIEF.md
# Display List Walker

This block steps through a display list stored in a 256-word by 32-bit list memory. It serves three output channels, and each channel has its own start pointer. When a walk begins, the block reads the header word at the channel's start pointer. It then hops to the next entry by adding the entry-size field of that header. The walk stops on an in-band end flag, on a size of zero, or when the next hop would run past the last word of the memory. Every header word it visits goes to a downstream consumer, together with its address and channel, over a valid/ready handshake.

A host fills the list memory through a write port and programs the start pointers. A channel requests a walk with a one-cycle go pulse. The request is honoured only while that channel's status mode allows list processing. Pending requests are served one whole walk at a time, in rotation. A low region of the list memory holds a boot-time list: it comes out of reset as end markers and cannot be overwritten by the host.

Top module: `dlist_walker`

## Requirements
- R1: Each of the three channels has its own start pointer, written through `ptr_we`/`ptr_sel`/`ptr_val`. A walk for channel c presents its first header from the address held in channel c's pointer.
- R2: The start pointer is sampled only when a walk is launched. A pointer write during a walk does not change that walk and takes effect at the channel's next walk.
- R3: A header word with bit 31 set ends the walk. That word is still presented, and no further word of the walk follows.
- R4: For a header without bit 31, the next presented address equals the current address plus the 6-bit size field in bits 29:24.
- R5: A header with bit 31 clear and a size field of zero is presented and then aborts the walk. It sets the channel's bit in `size_err`, which stays set until reset.
- R6: If the current address plus the size is 256 or more, the walk ends after the current word. The address never wraps.
- R7: A go pulse is accepted only when the channel's 2-bit mode (bits 2c+1:2c of `ch_mode`) is 1 or 2. Mode 0 (off) and mode 3 (end of frame) make the pulse have no effect, now or later.
- R8: Host writes to addresses below 16 are ignored. Those words read as 0x80000000 (a lone end marker) after reset.
- R9: While `hdr_valid` is high and `hdr_ready` is low, `hdr_valid`, `hdr_addr` and `hdr_chan` hold their values. One word is consumed per cycle with both high.
- R10: Pending channels are launched in rotation, starting after the channel served last. Channel 0 is first after reset, and each launch runs a complete walk.
- R11: After reset, `hdr_valid`, `walk_done` and `size_err` are all zero.
- R12: When a walk ends for any reason, `walk_done` pulses for one cycle on the bit of that channel. At most one bit is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host list-memory write strobe |
| wr_addr | input | 8 | Host write word address |
| wr_data | input | 32 | Host write data |
| ptr_we | input | 1 | Start pointer write strobe |
| ptr_sel | input | 2 | Channel whose start pointer is written |
| ptr_val | input | 8 | New start pointer value |
| ch_mode | input | 6 | Per-channel 2-bit status mode |
| walk_go | input | 3 | Per-channel walk request pulse |
| hdr_valid | output | 1 | Header word available |
| hdr_ready | input | 1 | Consumer accepts the header word |
| hdr_word | output | 32 | Header word read from the list |
| hdr_addr | output | 8 | Address of the presented word |
| hdr_chan | output | 2 | Channel being walked |
| walk_done | output | 3 | One-cycle end-of-walk pulse per channel |
| size_err | output | 3 | Sticky zero-size abort flag per channel |

## Verification
Two situations are hard to reach from the ports. The first is a pointer rewrite landing in the middle of a walk. The bench creates it by holding `hdr_ready` low after launch, so the walk is frozen on its first header while the pointer is written; releasing the consumer then shows the old chain. The second is the rotation order, which depends on which channel was served last. The bench fixes that history with a lone channel 0 walk before requesting all three channels in the same cycle. It then reads the order from the `walk_done` pulses. The memory-edge stop is reached by placing a chain near the top of the memory, with a final size that would cross address 255.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

  localparam int WORD_W   = 32;
  localparam int END_BIT  = 31;
  localparam int SIZE_LSB = 24;
  localparam int SIZE_W   = 6;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_FETCH = 2'd1,
    MODE_SCAN  = 2'd2,
    MODE_EOF   = 2'd3
  } ch_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;

  function automatic logic mode_can_walk(input logic [1:0] m);
    return (m == MODE_FETCH) || (m == MODE_SCAN);
  endfunction

  function automatic logic hdr_is_end(input logic [WORD_W-1:0] w);
    return w[END_BIT];
  endfunction

  function automatic logic [SIZE_W-1:0] hdr_size(input logic [WORD_W-1:0] w);
    return w[SIZE_LSB +: SIZE_W];
  endfunction

  function automatic logic [31:0] hop_target(input logic [31:0] base,
                                             input logic [SIZE_W-1:0] sz);
    return base + {{(32-SIZE_W){1'b0}}, sz};
  endfunction

endpackage

// File: rtl/dlw_list_ram.sv
module dlw_list_ram #(
  parameter int DEPTH      = 256,
  parameter int RSVD_WORDS = 16,
  parameter int AW         = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [dlw_pkg::WORD_W-1:0] wr_data,
  input  logic [AW-1:0]              rd_addr,
  output logic [dlw_pkg::WORD_W-1:0] rd_data
);
  import dlw_pkg::*;

  localparam logic [WORD_W-1:0] BOOT_WORD = WORD_W'(1) << END_BIT;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              wr_allowed;

  assign wr_allowed = wr_en && (32'(wr_addr) >= RSVD_WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RSVD_WORDS; i++) mem[i] <= BOOT_WORD;
    end else if (wr_allowed) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R8: a blocked write leaves the addressed word unchanged
  assert_rsvd_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_addr) < RSVD_WORDS)) |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));

endmodule

// File: rtl/dlw_rr_pick.sv
module dlw_rr_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] pick_idx,
  output logic          pick_any
);

  logic [IW-1:0] last_q;

  function automatic logic [IW:0] rr_search(input logic [N-1:0] r,
                                            input logic [IW-1:0] prev);
    logic [IW:0] res;
    int          idx;
    res = '0;
    for (int k = N; k >= 1; k--) begin
      idx = (int'(prev) + k) % N;
      if (r[idx]) res = {1'b1, IW'(idx)};
    end
    return res;
  endfunction

  logic [IW:0] found;
  assign found    = rr_search(req, last_q);
  assign pick_any = found[IW];
  assign pick_idx = found[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IW'(N-1);
    else if (take) last_q <= pick_idx;
  end

  // R10: a pick always lands on a requesting channel
  assert_pick_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> req[pick_idx]);

  // R10: any request yields a pick
  assert_pick_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> pick_any);

endmodule

// File: rtl/dlist_walker.sv
module dlist_walker #(
  parameter int CHANS      = 3,
  parameter int DEPTH      = 256,
  parameter int RSVD_WORDS = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int IW        = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 ptr_we,
  input  logic [IW-1:0]        ptr_sel,
  input  logic [AW-1:0]        ptr_val,
  input  logic [2*CHANS-1:0]   ch_mode,
  input  logic [CHANS-1:0]     walk_go,
  output logic                 hdr_valid,
  input  logic                 hdr_ready,
  output logic [31:0]          hdr_word,
  output logic [AW-1:0]        hdr_addr,
  output logic [IW-1:0]        hdr_chan,
  output logic [CHANS-1:0]     walk_done,
  output logic [CHANS-1:0]     size_err
);
  import dlw_pkg::*;

  walk_st_e                 st_q;
  logic [AW-1:0]            cur_addr_q;
  logic [IW-1:0]            cur_ch_q;
  logic [CHANS-1:0]         pend_q, done_q, err_q;
  logic [AW-1:0]            ptr_q [CHANS];
  logic [CHANS-1:0]         go_ok;
  logic [WORD_W-1:0]        rd_word;
  logic [IW-1:0]            pick_idx;
  logic                     pick_any;

  // named internal events
  logic                     launch, accept, walk_end, hop;
  logic                     at_end, zero_size, past_edge;
  logic [SIZE_W-1:0]        cur_size;
  logic [31:0]              next_full;
  logic [CHANS-1:0]         cur_mask, launch_mask;

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    assign go_ok[c] = walk_go[c] && mode_can_walk(ch_mode[2*c +: 2]);

    always_ff @(posedge clk) begin
      if (!rst_n)                               ptr_q[c] <= '0;
      else if (ptr_we && (ptr_sel == IW'(c)))   ptr_q[c] <= ptr_val;
    end
  end

  dlw_list_ram #(.DEPTH(DEPTH), .RSVD_WORDS(RSVD_WORDS), .AW(AW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (cur_addr_q),
    .rd_data (rd_word)
  );

  dlw_rr_pick #(.N(CHANS), .IW(IW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (pend_q),
    .take     (launch),
    .pick_idx (pick_idx),
    .pick_any (pick_any)
  );

  assign cur_size    = hdr_size(rd_word);
  assign at_end      = hdr_is_end(rd_word);
  assign zero_size   = !at_end && (cur_size == '0);
  assign next_full   = hop_target(32'(cur_addr_q), cur_size);
  assign past_edge   = next_full >= 32'(DEPTH);

  assign launch      = (st_q == ST_IDLE) && pick_any;
  assign accept      = (st_q == ST_WALK) && hdr_ready;
  assign walk_end    = accept && (at_end || zero_size || past_edge);
  assign hop         = accept && !walk_end;
  assign cur_mask    = CHANS'(1) << cur_ch_q;
  assign launch_mask = launch ? (CHANS'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cur_addr_q <= '0;
      cur_ch_q   <= '0;
      pend_q     <= '0;
      done_q     <= '0;
      err_q      <= '0;
    end else begin
      done_q <= '0;
      pend_q <= (pend_q & ~launch_mask) | go_ok;
      if (launch) begin
        st_q       <= ST_WALK;
        cur_ch_q   <= pick_idx;
        cur_addr_q <= ptr_q[pick_idx];
      end
      if (hop) cur_addr_q <= next_full[AW-1:0];
      if (walk_end) begin
        st_q   <= ST_IDLE;
        done_q <= cur_mask;
        if (zero_size) err_q <= err_q | cur_mask;
      end
    end
  end

  assign hdr_valid = (st_q == ST_WALK);
  assign hdr_word  = rd_word;
  assign hdr_addr  = cur_addr_q;
  assign hdr_chan  = cur_ch_q;
  assign walk_done = done_q;
  assign size_err  = err_q;

  // R9: a stalled header keeps its address and channel
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_addr) && $stable(hdr_chan)));

  // R4: after a hop the next address is the old one plus the size field
  assert_hop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hop |=> (hdr_valid && (hdr_addr == $past(hdr_addr) + AW'($past(cur_size)))));

  // R3: nothing is presented while a walk-end pulse is out
  assert_quiet_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|walk_done) |-> !hdr_valid);

  // R12: at most one channel completes at a time
  assert_done_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(walk_done));

  // R5: error flags never clear outside reset
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(size_err) & ~size_err) == '0));

endmodule

// File: tb/dlist_walker_bench.sv
`timescale 1ns/1ps
module dlist_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        ptr_we;
  logic [1:0]  ptr_sel;
  logic [7:0]  ptr_val;
  logic [5:0]  ch_mode;
  logic [2:0]  walk_go;
  logic        hdr_valid;
  logic        hdr_ready;
  logic [31:0] hdr_word;
  logic [7:0]  hdr_addr;
  logic [1:0]  hdr_chan;
  logic [2:0]  walk_done;
  logic [2:0]  size_err;

  int total = 0;
  int bad   = 0;

  logic [31:0] shadow [256];
  logic [7:0]  got_addr [64];
  logic [31:0] got_word [64];
  logic [1:0]  got_chan [64];
  int          got_n;
  logic [2:0]  got_done;
  logic [7:0]  exp_addr [64];
  int          exp_n;
  bit          exp_err;

  always #2.5 clk = ~clk;

  dlist_walker u_dlist_walker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_val(ptr_val), .ch_mode(ch_mode),
    .walk_go(walk_go), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_word(hdr_word), .hdr_addr(hdr_addr), .hdr_chan(hdr_chan),
    .walk_done(walk_done), .size_err(size_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 8'd16) shadow[a] = d;
  endtask

  task automatic set_ptr(input logic [1:0] ch, input logic [7:0] v);
    @(negedge clk);
    ptr_we = 1'b1; ptr_sel = ch; ptr_val = v;
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic pulse_go(input logic [2:0] m);
    @(negedge clk);
    walk_go = m;
    @(negedge clk);
    walk_go = '0;
  endtask

  // expected chain computed from the requirement rules
  task automatic build_exp(input logic [7:0] start);
    int a;
    logic [31:0] w;
    int sz;
    a = int'(start); exp_n = 0; exp_err = 1'b0;
    forever begin
      exp_addr[exp_n] = 8'(a); exp_n++;
      w = shadow[a];
      if (w[31]) break;
      sz = int'(w[29:24]);
      if (sz == 0) begin exp_err = 1'b1; break; end
      if (a + sz > 255) break;
      a = a + sz;
    end
  endtask

  task automatic collect();
    got_n = 0; got_done = '0;
    for (int t = 0; t < 2000 && got_done == 3'b000; t++) begin
      @(negedge clk);
      if (hdr_valid && hdr_ready && got_n < 64) begin
        got_addr[got_n] = hdr_addr; got_word[got_n] = hdr_word;
        got_chan[got_n] = hdr_chan; got_n++;
      end
      if (|walk_done) got_done = walk_done;
    end
  endtask

  task automatic compare_walk(input logic [1:0] ch, input logic [7:0] start,
                              input string req);
    build_exp(start);
    chk(got_done == (3'b001 << ch), {req, " done"}, 32'(got_done), 32'(3'b001 << ch));
    chk(got_n == exp_n, {req, " length"}, 32'(got_n), 32'(exp_n));
    for (int i = 0; i < got_n && i < exp_n; i++) begin
      chk(got_addr[i] == exp_addr[i], {req, " addr"}, 32'(got_addr[i]), 32'(exp_addr[i]));
      chk(got_word[i] == shadow[exp_addr[i]], {req, " word"}, got_word[i], shadow[exp_addr[i]]);
      chk(got_chan[i] == ch, {req, " chan"}, 32'(got_chan[i]), 32'(ch));
    end
  endtask

  task automatic t_reset();
    chk(hdr_valid == 1'b0, "R11 valid", 32'(hdr_valid), 0);
    chk(walk_done == 3'b000, "R11 done", 32'(walk_done), 0);
    chk(size_err == 3'b000, "R11 err", 32'(size_err), 0);
  endtask

  task automatic t_main_chain();
    host_write(8'd16, 32'h0300_0001);
    host_write(8'd19, 32'h0500_0002);
    host_write(8'd24, 32'h8000_0000);
    set_ptr(2'd0, 8'd16);
    pulse_go(3'b001);
    collect();
    compare_walk(2'd0, 8'd16, "R1 R3 R4 chain");
  endtask

  task automatic t_ptr_midwalk();
    hdr_ready = 1'b0;
    pulse_go(3'b001);
    for (int t = 0; t < 20 && !hdr_valid; t++) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(hdr_valid && hdr_addr == 8'd16, "R9 hold", {23'b0, hdr_valid, hdr_addr}, {23'b0, 1'b1, 8'd16});
      @(negedge clk);
    end
    ptr_we = 1'b1; ptr_sel = 2'd0; ptr_val = 8'd100;
    @(negedge clk);
    ptr_we = 1'b0;
    chk(hdr_addr == 8'd16, "R2 no change mid walk", 32'(hdr_addr), 32'd16);
    hdr_ready = 1'b1;
    got_n = 0; got_done = '0;
    for (int t = 0; t < 200 && got_done == 3'b000; t++) begin
      if (hdr_valid && got_n < 64) begin
        got_addr[got_n] = hdr_addr; got_word[got_n] = hdr_word;
        got_chan[got_n] = hdr_chan; got_n++;
      end
      @(negedge clk);
      if (|walk_done) got_done = walk_done;
    end
    compare_walk(2'd0, 8'd16, "R2 R9 old chain");
    host_write(8'd100, 32'h8000_0000);
    pulse_go(3'b001);
    collect();
    compare_walk(2'd0, 8'd100, "R2 new start");
  endtask

  task automatic t_reserved();
    host_write(8'd3, 32'h0500_0020);
    set_ptr(2'd1, 8'd3);
    pulse_go(3'b010);
    collect();
    compare_walk(2'd1, 8'd3, "R8 reserved");
    chk(got_word[0] == 32'h8000_0000, "R8 boot word", got_word[0], 32'h8000_0000);
  endtask

  task automatic t_edge();
    host_write(8'd250, 32'h0400_0011);
    host_write(8'd254, 32'h0800_0022);
    set_ptr(2'd1, 8'd250);
    pulse_go(3'b010);
    collect();
    compare_walk(2'd1, 8'd250, "R6 edge");
    chk(size_err == 3'b000, "R6 no err", 32'(size_err), 0);
  endtask

  task automatic t_zero_size();
    host_write(8'd40, 32'h0200_0000);
    host_write(8'd42, 32'h0000_0123);
    set_ptr(2'd2, 8'd40);
    pulse_go(3'b100);
    collect();
    compare_walk(2'd2, 8'd40, "R5 zero size");
    chk(size_err == 3'b100, "R5 err set", 32'(size_err), 32'b100);
    host_write(8'd44, 32'h8000_0000);
    set_ptr(2'd2, 8'd44);
    pulse_go(3'b100);
    collect();
    compare_walk(2'd2, 8'd44, "R5 later walk");
    chk(size_err == 3'b100, "R5 sticky", 32'(size_err), 32'b100);
  endtask

  task automatic t_mode_gate(input logic [1:0] m, input string req);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    ch_mode[3:2] = m;
    pulse_go(3'b010);
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      if (hdr_valid || (|walk_done)) seen = 1'b1;
    end
    chk(!seen, req, 32'(seen), 0);
    ch_mode[3:2] = 2'd2;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      if (hdr_valid || (|walk_done)) seen = 1'b1;
    end
    chk(!seen, {req, " no latent request"}, 32'(seen), 0);
    ch_mode[3:2] = 2'd1;
  endtask

  task automatic t_round_robin();
    logic [2:0] order [3];
    int n;
    set_ptr(2'd0, 8'd5);
    set_ptr(2'd1, 8'd6);
    set_ptr(2'd2, 8'd7);
    pulse_go(3'b001);
    collect();
    compare_walk(2'd0, 8'd5, "R10 lone walk");
    pulse_go(3'b111);
    n = 0;
    for (int t = 0; t < 200 && n < 3; t++) begin
      @(negedge clk);
      if (|walk_done) begin
        chk($countones(walk_done) == 1, "R12 one bit", 32'(walk_done), 0);
        order[n] = walk_done; n++;
      end
    end
    chk(n == 3, "R10 count", 32'(n), 3);
    if (n == 3) begin
      chk(order[0] == 3'b010, "R10 first", 32'(order[0]), 32'b010);
      chk(order[1] == 3'b100, "R10 second", 32'(order[1]), 32'b100);
      chk(order[2] == 3'b001, "R10 third", 32'(order[2]), 32'b001);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = (i < 16) ? 32'h8000_0000 : 32'h0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ptr_we = 1'b0; ptr_sel = '0; ptr_val = '0; ch_mode = 6'b01_01_01;
    walk_go = '0; hdr_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main_chain();
    t_ptr_midwalk();
    t_reserved();
    t_edge();
    t_zero_size();
    t_mode_gate(2'd0, "R7 mode off");
    t_mode_gate(2'd3, "R7 mode eof");
    t_round_robin();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule